// File: doc/BRIEF.md
# CORDIC Vectoring Magnitude and Phase Unit

This block converts a signed Cartesian sample (X, Y) into polar form: a magnitude and a phase angle in radians. It is a fully unrolled CORDIC engine run in vectoring mode. A quadrant fold first moves every input into the right half-plane and records a starting angle of 0, +pi/2 or -pi/2. A chain of micro-rotation stages then drives Y toward zero while the angle accumulator collects the matching arctangent steps. X finally holds the vector length, multiplied by the uncompensated CORDIC gain of about 1.6468.

Every stage has its own register, so a fresh sample can be applied on every clock. Each result appears a fixed number of cycles later. Both outputs are reduced to 8 bits with round-half-to-even, and then clamped to the 8-bit signed range. A synchronous active-low reset clears the whole pipeline.

Top module: `cordic_polar`

## Requirements
- R1: `mag_out` is a signed 8-bit code with 5 fraction bits (value = code/32). It is never negative. For inputs of length at least 1/4 it is within 1 LSB of 1.6468 * 32 * sqrt(x^2 + y^2), where x = `x_in`/128 and y = `y_in`/128. No gain compensation is applied.
- R2: `phase_out` is a signed 8-bit code with 5 fraction bits (value = code/32, in radians). For inputs of length at least 1/4 in any quadrant, it is within 1 LSB of 32 * atan2(y, x), and it never leaves -101..+101.
- R3: The latency is exactly 11 clock edges (`ITER` + 3 with the default `ITER` = 8): input register, quadrant fold, 8 micro-rotations and output register. A new sample is accepted on every edge, and back-to-back samples do not disturb each other.
- R4: The input (0, 0) gives `mag_out` = 0 and `phase_out` = 0.
- R5: The input X = -1.0 (code -128) with Y = 0 gives the phase +pi: a positive code within 1 LSB of 100.53 (that is, 100 or 101), never the negative end.
- R6: While `rst_n` is low, both outputs are 0 from the edge after it is sampled low, whatever the inputs are.
- R7: Full-scale corners do not overflow. (-1.0, -1.0) gives a magnitude within 1 LSB of 74.53 and a phase within 1 LSB of -75.40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear of all pipeline registers |
| x_in | input | 8 | X component, signed fraction with 7 fraction bits |
| y_in | input | 8 | Y component, signed fraction with 7 fraction bits |
| mag_out | output | 8 | Magnitude times the CORDIC gain, signed with 5 fraction bits |
| phase_out | output | 8 | Angle in radians, signed with 5 fraction bits |

## Verification
In the same clock, the quadrant fold can be remapping one sample while the final rounding stage is reducing an older sample from another quadrant. The directed stream task triggers this by applying a different vector on every edge, with its quadrants interleaved and with zero vectors in between. Each output slot is then compared, exactly 11 edges after its input, against a real-valued atan2 and hypotenuse model scaled by the gain. Any leakage between neighbouring samples, or any slip in latency, shows up as a mismatch in that slot.

// File: rtl/cordic_polar_pkg.sv
`timescale 1ns/1ps
package cordic_polar_pkg;

    // Angle step of micro-rotation idx, atan(2^-idx), as an integer with frac fraction bits
    function automatic int angle_code(input int idx, input int frac);
        real a;
        a = $atan(1.0 / (2.0 ** idx));
        return int'(a * (2.0 ** frac));
    endfunction

    // pi/2 with frac fraction bits
    function automatic int half_pi_code(input int frac);
        return int'(1.5707963267948966 * (2.0 ** frac));
    endfunction

    // pi with frac fraction bits
    function automatic int pi_code(input int frac);
        return int'(3.141592653589793 * (2.0 ** frac));
    endfunction

endpackage

// File: rtl/cordic_polar_fold.sv
`timescale 1ns/1ps
module cordic_polar_fold
    import cordic_polar_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int GUARD = 3,
    parameter int W     = 13,
    parameter int PW    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [IN_W-1:0] x_i,
    input  logic signed [IN_W-1:0] y_i,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic signed [PW-1:0] z_o
);
    localparam int EXT = W - IN_W - GUARD;
    localparam int HP  = half_pi_code(PW - 3);
    localparam logic signed [PW-1:0] HP_V = PW'(HP);

    logic signed [W-1:0]  xe, ye;
    logic signed [W-1:0]  x_n, y_n;
    logic signed [PW-1:0] z_n;

    assign xe = {{EXT{x_i[IN_W-1]}}, x_i, {GUARD{1'b0}}};
    assign ye = {{EXT{y_i[IN_W-1]}}, y_i, {GUARD{1'b0}}};

    // Quadrant fold into the right half-plane
    always_comb begin
        if (!xe[W-1]) begin
            x_n = xe;
            y_n = ye;
            z_n = '0;
        end else if (!ye[W-1]) begin
            // second quadrant: turn by -90 degrees
            x_n = ye;
            y_n = -xe;
            z_n = HP_V;
        end else begin
            // third quadrant: turn by +90 degrees
            x_n = -ye;
            y_n = xe;
            z_n = -HP_V;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            x_o <= x_n;
            y_o <= y_n;
            z_o <= z_n;
        end
    end

    AST_RIGHT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (x_o >= 0)); // R2

endmodule

// File: rtl/cordic_polar_stage.sv
`timescale 1ns/1ps
module cordic_polar_stage
    import cordic_polar_pkg::*;
#(
    parameter int W   = 13,
    parameter int PW  = 13,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [W-1:0]  x_i,
    input  logic signed [W-1:0]  y_i,
    input  logic signed [PW-1:0] z_i,
    output logic signed [W-1:0]  x_o,
    output logic signed [W-1:0]  y_o,
    output logic signed [PW-1:0] z_o
);
    localparam int ANG = angle_code(IDX, PW - 3);
    localparam logic signed [PW-1:0] ANG_V = PW'(ANG);

    logic signed [W-1:0]  xsh, ysh;
    logic signed [W-1:0]  x_n, y_n;
    logic signed [PW-1:0] z_n;
    logic                 hold;

    assign xsh  = x_i >>> IDX;
    assign ysh  = y_i >>> IDX;
    assign hold = (x_i == '0) && (y_i == '0);

    // Turn against the sign of Y and accumulate the step angle
    always_comb begin
        if (hold) begin
            x_n = x_i;
            y_n = y_i;
            z_n = z_i;
        end else if (y_i[W-1]) begin
            x_n = x_i - ysh;
            y_n = y_i + xsh;
            z_n = z_i - ANG_V;
        end else begin
            x_n = x_i + ysh;
            y_n = y_i - xsh;
            z_n = z_i + ANG_V;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            x_o <= x_n;
            y_o <= y_n;
            z_o <= z_n;
        end
    end

    AST_X_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (x_o >= $past(x_i))); // R1
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (x_i == '0 && y_i == '0 && z_i == '0) |=> (x_o == '0 && y_o == '0 && z_o == '0)); // R4

endmodule

// File: rtl/cordic_polar_round.sv
`timescale 1ns/1ps
module cordic_polar_round #(
    parameter int W  = 13,
    parameter int S  = 5,
    parameter int OW = 8
) (
    input  logic signed [W-1:0]  v,
    output logic signed [OW-1:0] q
);
    localparam logic signed [W-1:0] HI = W'((1 <<< (OW - 1)) - 1);
    localparam logic signed [W-1:0] LO = W'(-(1 <<< (OW - 1)));

    logic signed [W-1:0] q0, r;
    logic [S-1:0]        rem;
    logic                up;

    assign q0  = v >>> S;
    assign rem = v[S-1:0];
    // above half, or exactly half with an odd quotient
    assign up  = rem[S-1] & ((|rem[S-2:0]) | q0[0]);

    always_comb begin
        r = up ? (q0 + W'(1)) : q0;
        if (r > HI)      q = HI[OW-1:0];
        else if (r < LO) q = LO[OW-1:0];
        else             q = r[OW-1:0];
    end

endmodule

// File: rtl/cordic_polar.sv
`timescale 1ns/1ps
module cordic_polar
    import cordic_polar_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8,
    parameter int ITER  = 8,
    parameter int GUARD = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [IN_W-1:0]   x_in,
    input  logic signed [IN_W-1:0]   y_in,
    output logic signed [OUT_W-1:0]  mag_out,
    output logic signed [OUT_W-1:0]  phase_out
);
    localparam int IN_FRAC  = IN_W - 1;
    localparam int OUT_FRAC = OUT_W - 3;
    localparam int X_FRAC   = IN_FRAC + GUARD;
    localparam int W        = IN_W + 2 + GUARD;
    localparam int PF       = X_FRAC;
    localparam int PW       = PF + 3;
    localparam int LATENCY  = ITER + 3;
    localparam int PI_CODE  = pi_code(OUT_FRAC);

    logic signed [IN_W-1:0] x_r, y_r;
    logic signed [W-1:0]    xs [0:ITER];
    logic signed [W-1:0]    ys [0:ITER];
    logic signed [PW-1:0]   zs [0:ITER];
    logic signed [OUT_W-1:0] mag_n, ph_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_r <= '0;
            y_r <= '0;
        end else begin
            x_r <= x_in;
            y_r <= y_in;
        end
    end

    cordic_polar_fold #(.IN_W(IN_W), .GUARD(GUARD), .W(W), .PW(PW)) u_fold (
        .clk(clk), .rst_n(rst_n), .x_i(x_r), .y_i(y_r),
        .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0])
    );

    for (genvar i = 0; i < ITER; i++) begin : g_stage
        cordic_polar_stage #(.W(W), .PW(PW), .IDX(i)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .x_i(xs[i]), .y_i(ys[i]), .z_i(zs[i]),
            .x_o(xs[i+1]), .y_o(ys[i+1]), .z_o(zs[i+1])
        );
    end

    cordic_polar_round #(.W(W), .S(X_FRAC - OUT_FRAC), .OW(OUT_W)) u_rnd_mag (
        .v(xs[ITER]), .q(mag_n)
    );
    cordic_polar_round #(.W(PW), .S(PF - OUT_FRAC), .OW(OUT_W)) u_rnd_ph (
        .v(zs[ITER]), .q(ph_n)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_out   <= '0;
            phase_out <= '0;
        end else begin
            mag_out   <= mag_n;
            phase_out <= ph_n;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (mag_out == '0 && phase_out == '0)); // R6
    AST_MAG_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        mag_out >= 0); // R1
    AST_PHASE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_out) <= PI_CODE) && (int'(phase_out) >= -PI_CODE)); // R2

endmodule

// File: tb/cordic_polar_test.sv
`timescale 1ns/1ps
module cordic_polar_test;
    localparam int LAT  = 11;
    localparam int NSTR = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [7:0] x_in = '0, y_in = '0;
    logic signed [7:0] mag_out, phase_out;

    int n_chk = 0;
    int n_fail = 0;
    real gain;

    cordic_polar uut (.clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in),
                      .mag_out(mag_out), .phase_out(phase_out));

    always #10 clk = ~clk;

    function automatic real exp_mag(input int x, input int y);
        return gain * 32.0 * $sqrt(real'(x*x + y*y)) / 128.0;
    endfunction

    function automatic real exp_ph(input int x, input int y);
        if (x == 0 && y == 0) return 0.0;
        return 32.0 * $atan2(real'(y), real'(x));
    endfunction

    task automatic near(input int act, input real expv, input string tag);
        real d;
        n_chk++;
        d = real'(act) - expv;
        if (d > 1.0 || d < -1.0) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %f", tag, act, expv);
        end
    endtask

    task automatic exact(input int act, input int expv, input string tag);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic hold_and_check(input int x, input int y, input string tag);
        @(negedge clk);
        x_in = 8'(x);
        y_in = 8'(y);
        repeat (LAT) @(negedge clk);
        near(int'(mag_out), exp_mag(x, y), {tag, " mag"});
        near(int'(phase_out), exp_ph(x, y), {tag, " phase"});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        x_in = 8'sd100;
        y_in = 8'sd50;
        repeat (LAT + 2) @(negedge clk);
        exact(int'(mag_out), 0, "R6 reset mag");
        exact(int'(phase_out), 0, "R6 reset phase");
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        @(negedge clk);
        x_in = 0; y_in = 0;
        repeat (LAT) @(negedge clk);
        x_in = 8'sd100; y_in = 0;
        @(negedge clk);
        x_in = 0;
        repeat (LAT - 2) @(negedge clk);
        exact(int'(mag_out), 0, "R3 not before latency");
        @(negedge clk);
        near(int'(mag_out), exp_mag(100, 0), "R3 at latency mag");
        near(int'(phase_out), 0.0, "R3 at latency phase");
        @(negedge clk);
        exact(int'(mag_out), 0, "R3 single slot");
    endtask

    task automatic t_zero();
        hold_and_check(0, 0, "R4 zero");
        exact(int'(mag_out), 0, "R4 zero mag exact");
        exact(int'(phase_out), 0, "R4 zero phase exact");
    endtask

    task automatic t_neg_unity();
        hold_and_check(-128, 0, "R5 minus one");
        n_chk++;
        if (!(phase_out == 8'sd100 || phase_out == 8'sd101)) begin
            n_fail++;
            $display("FAIL R5 sign: actual %0d expected 100 or 101", phase_out);
        end
    endtask

    task automatic t_corner();
        hold_and_check(-128, -128, "R7 corner");
        hold_and_check(127, 127, "R7 corner pos");
        hold_and_check(-128, -1, "R2 near minus pi");
    endtask

    task automatic t_stream();
        int xv [NSTR] = '{100, 0, -100, 0, 90, -70, -45, 0, 120, 64, -128, 40, 0, -90, 75, -33};
        int yv [NSTR] = '{0, 100, 0, -100, -60, 50, -110, 0, 30, 64, 64, -110, 0, -90, -75, 96};
        for (int c = 0; c < NSTR + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) begin
                near(int'(mag_out), exp_mag(xv[c-LAT], yv[c-LAT]), "R1 R3 stream mag");
                near(int'(phase_out), exp_ph(xv[c-LAT], yv[c-LAT]), "R2 R3 stream phase");
            end
            if (c < NSTR) begin
                x_in = 8'(xv[c]);
                y_in = 8'(yv[c]);
            end else begin
                x_in = 0;
                y_in = 0;
            end
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        gain = 1.0;
        for (int i = 0; i < 8; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2 * i));
        t_reset();
        t_latency();
        t_zero();
        t_neg_unity();
        t_corner();
        t_stream();
        report();
    end

endmodule